// File: doc/BRIEF.md
# Rate-Corrected Precision Time Clock

This block keeps two nanosecond time counters side by side. One is a free-running count that only ever steps by the nominal 8 ns period. The other is a corrected clock that software can steer. A 32-bit fractional rate word feeds an accumulator, and each carry out of that accumulator adds one extra nanosecond to the corrected clock's step. Software can also replace the corrected clock with a new 64-bit value, or add a signed 64-bit offset to it. A command word chooses which of these two updates a commit performs. The same command word also starts and stops the scheduler enable and the pulse-per-second enable, selects which counter drives the timestamp output, and clears both counters.

Software reaches the block over a word-addressed request/response stream. The request channel uses valid/ready. Writes produce no response. Each read produces exactly one response beat on a valid/ready response channel. Back-pressure works as follows. A request is accepted only when no response is waiting, or when the waiting response is consumed in the same cycle. An unaccepted response keeps its data stable.

Time reads are atomic. A read of a counter's low word copies the full 64-bit value into a shadow register in the cycle the request is accepted. A later read returns the upper half from that shadow. A 64-bit time load works the same way: the low half is staged first, and the clock changes only when the upper half arrives.

Top module: `ptp_rate_clock`

## Requirements
- R1: After reset, both counters, the rate word, the staged value and the shadow are zero. The scheduler and pulse enables are off, the timestamp output follows the free-running counter, commits overwrite, and no response is pending.
- R2: The free-running counter `time_free` increases by exactly 8 every cycle, except during a clear.
- R3: Each cycle, the 32-bit rate word is added to a 32-bit fractional accumulator. The corrected clock `time_corr` then advances by 8 plus that addition's carry out.
- R4: A write to address 1 stages a low word and does not change the clock. A write to address 2 commits {written word, staged low word}. In overwrite mode, `time_corr` equals that value one cycle after acceptance.
- R5: When command bit 5 was last written as 1, a commit adds the 64-bit two's-complement value to the clock, on top of the normal step for that cycle. This allows both forward and backward adjustment.
- R6: A read of address 3 returns the low word of `time_corr` as it stood in the acceptance cycle, and latches all 64 bits into the shadow. A read of address 5 returns the shadow's upper word, even if the clock has since carried into its upper half.
- R7: A read of address 4 does the same for `time_free`: it returns the low word and latches all 64 bits into the shadow.
- R8: On a command write (address 0), bit 0 starts the scheduler and bit 1 stops it, and stop wins when both are set. A command read returns bit 0 = running and bit 1 = stopped. All other command bits read as zero.
- R9: Command bits 2 and 3 turn `pps_en` on and off, and off wins when both are set. Bit 4 makes `ts_now` follow `time_corr` when 1 and `time_free` when 0. Bits 4 and 5 are replaced on every command write.
- R10: Command bit 6 clears both counters and the fractional accumulator at the second clock edge after acceptance. Counting then resumes from zero, and the bit reads back as zero.
- R11: Address 6 holds the rate word and reads back what was last written. The new rate takes effect in the cycle after the write.
- R12: `req_ready` is low exactly when a response is valid and `rsp_ready` is low. A response that is not accepted keeps `rsp_valid` and `rsp_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read data |
| time_corr | output | 64 | Corrected clock, ns |
| time_free | output | 64 | Free-running counter, ns |
| ts_now | output | 64 | Counter selected as timestamp source |
| sched_run | output | 1 | Scheduler enable state |
| pps_en | output | 1 | Pulse-per-second enable state |

## Verification
The clock is exercised under several rate words: zero, which must give a plain 8 ns step; one half, which must add a nanosecond on every other cycle; and all ones, which must carry on almost every cycle. Comparing these three separates a missing carry from one that is taken too often. Commits are tried in overwrite mode and in add mode, with both a positive and a negative offset, and a low-word write is left uncommitted for several cycles to show that staging alone changes nothing. A time read is placed just below a 32-bit carry, so a stale or non-atomic upper half is exposed. A held response with a second request queued behind it checks the back-pressure rules.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CMD       = 3'd0,
    A_VAL_LO    = 3'd1,
    A_VAL_HI    = 3'd2,
    A_CORR_LO   = 3'd3,
    A_FREE_LO   = 3'd4,
    A_SHADOW_HI = 3'd5,
    A_RATE      = 3'd6
  } reg_addr_e;

  // command word bit positions
  localparam int CB_SCH_GO   = 0;
  localparam int CB_SCH_HALT = 1;
  localparam int CB_PPS_GO   = 2;
  localparam int CB_PPS_HALT = 3;
  localparam int CB_TS_CORR  = 4;
  localparam int CB_ADD_MODE = 5;
  localparam int CB_CLEAR    = 6;
endpackage

// File: rtl/ptp_cmd_reg.sv
module ptp_cmd_reg
  import ptp_clk_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic              sched_run,
  output logic              pps_en,
  output logic              ts_from_corr,
  output logic              add_mode,
  output logic              clr_pulse,
  output logic [WORD_W-1:0] rdata
);
  logic unused_hi;
  assign unused_hi = ^wdata[WORD_W-1:CB_CLEAR+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sched_run    <= 1'b0;
      pps_en       <= 1'b0;
      ts_from_corr <= 1'b0;
      add_mode     <= 1'b0;
      clr_pulse    <= 1'b0;
    end else begin
      clr_pulse <= wr_en && wdata[CB_CLEAR];
      if (wr_en) begin
        ts_from_corr <= wdata[CB_TS_CORR];
        add_mode     <= wdata[CB_ADD_MODE];
        if (wdata[CB_SCH_HALT])    sched_run <= 1'b0;
        else if (wdata[CB_SCH_GO]) sched_run <= 1'b1;
        if (wdata[CB_PPS_HALT])    pps_en <= 1'b0;
        else if (wdata[CB_PPS_GO]) pps_en <= 1'b1;
      end
    end
  end

  // only the scheduler state is visible; write-only bits read as zero
  always_comb begin
    rdata = '0;
    rdata[CB_SCH_GO]   = sched_run;
    rdata[CB_SCH_HALT] = !sched_run;
  end

  // R8
  // sched_stop_wins_chk
  sched_stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata[CB_SCH_HALT] |=> !sched_run);

  // R8
  // sched_start_chk
  sched_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata[CB_SCH_GO] && !wdata[CB_SCH_HALT] |=> sched_run);

  // R9
  // pps_stop_wins_chk
  pps_stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata[CB_PPS_HALT] |=> !pps_en);
endmodule

// File: rtl/ptp_tick_ctr.sv
module ptp_tick_ctr #(
  parameter int TIME_W     = 64,
  parameter int FRAC_W     = 32,
  parameter int NOMINAL_NS = 8,
  parameter bit HAS_RATE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_en,
  input  logic              load_add,
  input  logic [TIME_W-1:0] load_val,
  input  logic [FRAC_W-1:0] rate,
  output logic [TIME_W-1:0] count
);
  localparam logic [TIME_W-1:0] NOM = TIME_W'(NOMINAL_NS);

  logic              carry;
  logic [TIME_W-1:0] step;
  logic [TIME_W-1:0] next;

  generate
    if (HAS_RATE) begin : g_rate
      logic [FRAC_W-1:0] frac_q;
      logic [FRAC_W:0]   sum;
      assign sum   = {1'b0, frac_q} + {1'b0, rate};
      assign carry = sum[FRAC_W];
      always_ff @(posedge clk) begin
        if (!rst_n || clr) frac_q <= '0;
        else               frac_q <= sum[FRAC_W-1:0];
      end
    end else begin : g_fixed
      logic unused_ins;
      assign unused_ins = ^{load_en, load_add, load_val, rate};
      assign carry = 1'b0;
    end
  endgenerate

  assign step = NOM + {{(TIME_W-1){1'b0}}, carry};

  always_comb begin
    if (HAS_RATE && load_en)
      next = load_add ? (count + step + load_val) : load_val;
    else
      next = count + step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else               count <= next;
  end

  // R2 R3
  // step_size_chk
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !(HAS_RATE && load_en) |=>
      (count == $past(count) + NOM) || (HAS_RATE && (count == $past(count) + NOM + 1)));
endmodule

// File: rtl/ptp_rate_clock.sv
module ptp_rate_clock
  import ptp_clk_pkg::*;
#(
  parameter  int WORD_W     = 32,
  parameter  int NOMINAL_NS = 8,
  localparam int TIME_W     = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic [TIME_W-1:0] time_corr,
  output logic [TIME_W-1:0] time_free,
  output logic [TIME_W-1:0] ts_now,
  output logic              sched_run,
  output logic              pps_en
);
  reg_addr_e         addr;
  logic              fire, wr, rd;
  logic              ts_from_corr, add_mode, clr_pulse;
  logic [WORD_W-1:0] cmd_rdata, rd_mux;
  logic [WORD_W-1:0] val_lo_q, rate_q;
  logic [TIME_W-1:0] shadow_q, load_val;
  logic              load_en;

  assign addr      = reg_addr_e'(req_addr);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr        = fire && req_write;
  assign rd        = fire && !req_write;
  assign load_en   = wr && (addr == A_VAL_HI);
  assign load_val  = {req_wdata, val_lo_q};

  ptp_cmd_reg #(.WORD_W(WORD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr && (addr == A_CMD)), .wdata(req_wdata),
    .sched_run(sched_run), .pps_en(pps_en), .ts_from_corr(ts_from_corr),
    .add_mode(add_mode), .clr_pulse(clr_pulse), .rdata(cmd_rdata)
  );

  ptp_tick_ctr #(.TIME_W(TIME_W), .FRAC_W(WORD_W), .NOMINAL_NS(NOMINAL_NS), .HAS_RATE(1'b1)) u_corr (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse),
    .load_en(load_en), .load_add(add_mode), .load_val(load_val),
    .rate(rate_q), .count(time_corr)
  );

  ptp_tick_ctr #(.TIME_W(TIME_W), .FRAC_W(WORD_W), .NOMINAL_NS(NOMINAL_NS), .HAS_RATE(1'b0)) u_free (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse),
    .load_en(1'b0), .load_add(1'b0), .load_val('0),
    .rate('0), .count(time_free)
  );

  assign ts_now = ts_from_corr ? time_corr : time_free;

  always_comb begin
    unique case (addr)
      A_CMD:       rd_mux = cmd_rdata;
      A_CORR_LO:   rd_mux = time_corr[WORD_W-1:0];
      A_FREE_LO:   rd_mux = time_free[WORD_W-1:0];
      A_SHADOW_HI: rd_mux = shadow_q[TIME_W-1:WORD_W];
      A_RATE:      rd_mux = rate_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_lo_q  <= '0;
      rate_q    <= '0;
      shadow_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (wr && addr == A_VAL_LO) val_lo_q <= req_wdata;
      if (wr && addr == A_RATE)   rate_q   <= req_wdata;
      if (rd && addr == A_CORR_LO) shadow_q <= time_corr;
      if (rd && addr == A_FREE_LO) shadow_q <= time_free;
      if (rd) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R12
  // rsp_hold_chk
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R4
  // commit_overwrite_chk
  commit_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && !add_mode && !clr_pulse |=> time_corr == $past(load_val));

  // R10
  // clear_zero_chk
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> time_corr == '0 && time_free == '0);
endmodule

// File: tb/ptp_rate_clock_tb.sv
`timescale 1ns/100ps
module ptp_rate_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, sched_run, pps_en;
  logic [31:0] rsp_data;
  logic [63:0] time_corr, time_free, ts_now;

  always #2.5 clk = ~clk;

  ptp_rate_clock dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .time_corr(time_corr), .time_free(time_free), .ts_now(ts_now),
    .sched_run(sched_run), .pps_en(pps_en)
  );

  // behavioural reference
  longint unsigned m_corr, m_free, m_shadow;
  logic [31:0] m_frac, m_rate, m_vlo, m_rdata;
  logic m_sched, m_pps, m_tsc, m_add, m_clr, m_rvalid;
  int compared = 0, mismatched = 0;
  string phase = "R1 reset";
  bit done = 0;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, !m_sched, m_sched};
      3'd3: return m_corr[31:0];
      3'd4: return m_free[31:0];
      3'd5: return m_shadow[63:32];
      3'd6: return m_rate;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_corr = 0; m_free = 0; m_shadow = 0; m_frac = 0; m_rate = 0; m_vlo = 0;
      m_rdata = 0; m_sched = 0; m_pps = 0; m_tsc = 0; m_add = 0; m_clr = 0; m_rvalid = 0;
    end else begin
      logic fire; logic [32:0] sum; longint unsigned step, nc, nf, lv;
      logic [31:0] nrd; logic nclr;
      fire = req_valid && (!m_rvalid || rsp_ready);
      sum  = {1'b0, m_frac} + {1'b0, m_rate};
      step = 8 + longint'(sum[32]);
      lv   = {req_wdata, m_vlo};
      nc   = m_corr + step;
      if (fire && req_write && req_addr == 3'd2) nc = m_add ? m_corr + step + lv : lv;
      nf   = m_free + 8;
      nrd  = model_read(req_addr);
      nclr = fire && req_write && req_addr == 3'd0 && req_wdata[6];
      if (fire && !req_write) begin
        if (req_addr == 3'd3) m_shadow = m_corr;
        if (req_addr == 3'd4) m_shadow = m_free;
        m_rvalid = 1; m_rdata = nrd;
      end else if (rsp_ready) m_rvalid = 0;
      if (fire && req_write) begin
        case (req_addr)
          3'd0: begin
            m_tsc = req_wdata[4]; m_add = req_wdata[5];
            if (req_wdata[1]) m_sched = 0; else if (req_wdata[0]) m_sched = 1;
            if (req_wdata[3]) m_pps = 0;   else if (req_wdata[2]) m_pps = 1;
          end
          3'd1: m_vlo  = req_wdata;
          3'd6: m_rate = req_wdata;
          default: ;
        endcase
      end
      if (m_clr) begin m_corr = 0; m_free = 0; m_frac = 0; end
      else begin m_corr = nc; m_free = nf; m_frac = sum[31:0]; end
      m_clr = nclr;
    end
  end

  task automatic cmp(input string what, input longint unsigned act, input longint unsigned exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("time_corr", time_corr, m_corr);
    cmp("time_free", time_free, m_free);
    cmp("ts_now", ts_now, m_tsc ? m_corr : m_free);
    cmp("sched_run", 64'(sched_run), 64'(m_sched));
    cmp("pps_en", 64'(pps_en), 64'(m_pps));
    cmp("req_ready", 64'(req_ready), 64'(!m_rvalid || rsp_ready));
    cmp("rsp_valid", 64'(rsp_valid), 64'(m_rvalid));
    if (m_rvalid) cmp("rsp_data", 64'(rsp_data), 64'(m_rdata));
  end

  task automatic bus(input logic w, input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(4); #1; rst_n = 1;
    phase = "R2 R3 nominal step";      idle(10);
    phase = "R11 R3 half rate";        bus(1, 3'd6, 32'h8000_0000); bus(0, 3'd6, 0); idle(10);
    phase = "R3 full rate";            bus(1, 3'd6, 32'hFFFF_FFFF); idle(10);
    bus(1, 3'd6, 32'd0);
    phase = "R4 staged low only";      bus(1, 3'd1, 32'h0000_1234); idle(4);
    phase = "R4 overwrite commit";     bus(1, 3'd2, 32'h0000_0005); idle(3);
    phase = "R6 atomic corr read";     bus(1, 3'd1, 32'hFFFF_FFF0); bus(1, 3'd2, 32'h1);
                                       bus(0, 3'd3, 0); idle(4); bus(0, 3'd5, 0); idle(2);
    phase = "R7 free shadow read";     bus(0, 3'd4, 0); bus(0, 3'd5, 0); idle(2);
    phase = "R5 add positive";         bus(1, 3'd0, 32'h20); bus(1, 3'd1, 32'd100); bus(1, 3'd2, 0); idle(2);
    phase = "R5 add negative";         bus(1, 3'd1, 32'hFFFF_FF00); bus(1, 3'd2, 32'hFFFF_FFFF); idle(2);
    phase = "R8 scheduler start";      bus(1, 3'd0, 32'h1); bus(0, 3'd0, 0); idle(2);
    phase = "R8 stop wins";            bus(1, 3'd0, 32'h3); bus(0, 3'd0, 0); idle(2);
    phase = "R9 pps and ts source";    bus(1, 3'd0, 32'h14); idle(3); bus(1, 3'd0, 32'h0C); idle(3);
    phase = "R10 clear";               bus(1, 3'd0, 32'h41); idle(4); bus(0, 3'd0, 0); idle(2);
    phase = "R12 back-pressure";       rsp_ready = 0; bus(0, 3'd3, 0);
    fork
      bus(0, 3'd6, 0);
      begin idle(5); #1; rsp_ready = 1; end
    join
    idle(4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule